// File: doc/BRIEF.md
# Sync-Word Pilot and Parity Checker

This block sits behind a 64b/66b block aligner on one receive lane. It takes one aligned 66-bit block per `blk_valid` cycle. The upper two bits are the sync header and the lower 64 bits are the payload. The header has two jobs. It proves that block alignment holds, and it carries one bit of a 32-bit sync word. Thirty-two consecutive blocks make one multiblock. Each multiblock therefore delivers one sync word, which holds a pilot pattern, an extended-multiblock marker, a command field with a parity bit, and a 12-bit CRC over the payload of the previous multiblock.

The checker works through three stages, and each stage waits for the one before it:

1. It hunts for header lock.
2. It finds the multiblock boundary from the pilot pattern.
3. It locks to the extended multiblock of `EMB_LEN` multiblocks.

Each error is reported as a one-cycle pulse. The checker gives up a lock on its own after repeated failures and then starts searching again without any outside help. The extracted command bits are presented together with a one-cycle `cmd_valid` strobe.

Sync word layout:
- Bit position k of the sync word comes from block k of the multiblock. Header 10 contributes a 1 and header 01 contributes a 0.
- Pilot positions are 4j+3. Positions 15, 19, 23, 27 and 31 must read 0,0,0,0,1. Position 11 is the extended-multiblock marker. Positions 3 and 7 are ignored.
- The other 24 positions, in ascending order, carry two fields:
  - The first 12 carry the CRC, MSB first.
  - The last 12 carry 11 command bits, MSB first, followed by an even-parity bit at position 30.

Top module: `syncword_checker`

## Requirements
- R1: `sh_locked` rises one cycle after the 64th consecutive accepted block whose header is 01 or 10. Any invalid header before that restarts the count.
- R2: While header-locked, every accepted block with header 00 or 11 gives exactly one `hdr_err` pulse one cycle later. No `hdr_err` occurs before lock.
- R3: Once locked, the accepted blocks are counted in fixed windows of 64, starting at the block after lock. When the 16th invalid header within one window arrives, the block pulses `sh_unlock_err` and clears `sh_locked`, `mb_aligned` and `emb_locked`. Fifteen invalid headers within a window keep the lock. Header lock is then regained by R1 with no outside action.
- R4: While header-locked and not yet aligned, the block on which the last 32 sync bits show 0,0,0,0,1 at positions 15/19/23/27/31 is taken as position 31. `mb_aligned` rises one cycle later.
- R5: At each aligned multiblock end whose pilot bits differ from 0,0,0,0,1, the block does the following:
  - It pulses `eomb_err` and clears `mb_aligned`.
  - It raises no `cmd_valid`, `cmd_par_err` or `crc_err` for that word.
  - It drops `emb_locked`, with an `emb_unlock_err` pulse if that lock was held.
- R6: Each multiblock end that passes the pilot check pulses `cmd_valid` and loads `cmd_bits` from positions 16,17,18,20,21,22,24,25,26,28,29, with position 16 as bit 10. `cmd_par_err` pulses when the XOR of those bits and position 30 is 1. `cmd_bits` does not change without `cmd_valid`.
- R7: The CRC is CRC-12, polynomial 0x80F, initial value 0. It is computed over each block's 64-bit payload, bit 63 first, across one aligned multiblock. The CRC field (positions 0,1,2,4,5,6,8,9,10,12,13,14, with position 0 as MSB) of the next multiblock must equal it, otherwise `crc_err` pulses. The CRC is not checked on the first multiblock after alignment.
- R8: `emb_locked` rises after two marker bits (position 11) equal to 1 that lie exactly `EMB_LEN` multiblocks apart.
- R9: While `emb_locked` is set, the marker must be 1 on every `EMB_LEN`-th multiblock and 0 on all others. A mismatch pulses `eoemb_err` and `emb_unlock_err`, clears `emb_locked`, and restarts the marker search.
- R10: All outputs change only on accepted blocks (`blk_valid` high). A cycle with `blk_valid` low has no effect, whatever data it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A block is present on `blk` |
| blk | input | 66 | Sync header [65:64] and payload [63:0] |
| sh_locked | output | 1 | Header lock held |
| mb_aligned | output | 1 | Multiblock boundary found |
| emb_locked | output | 1 | Extended-multiblock lock held |
| hdr_err | output | 1 | Invalid header pulse |
| eomb_err | output | 1 | Pilot pattern mismatch pulse |
| eoemb_err | output | 1 | Extended-multiblock marker mismatch pulse |
| cmd_par_err | output | 1 | Command parity mismatch pulse |
| crc_err | output | 1 | CRC mismatch pulse |
| sh_unlock_err | output | 1 | Header lock lost pulse |
| emb_unlock_err | output | 1 | Extended-multiblock lock lost pulse |
| cmd_valid | output | 1 | New command bits strobe |
| cmd_bits | output | 11 | Last command field received |

## Verification
The bench tests the lock threshold from both sides: 63 good headers must not lock, the 64th must, and 15 bad headers in one window must keep the lock while the 16th drops it. A counter that is off by one, or a window that never clears, shows up as a lock or unlock one block early or late. The first CRC check after alignment is a deliberate trap: a checker that compares against a CRC it never fully computed raises a false `crc_err`. A corrupted pilot word must produce no command or CRC reports, and realignment must follow on the next clean multiblock. The bench also breaks the marker and then relocks, which exposes a checker that stays locked, or one that counts the extended multiblock from the wrong marker.

// File: rtl/syncword_checker.sv
module syncword_checker #(
  parameter int EMB_LEN    = 4,
  parameter int LOCK_GOOD  = 64,
  parameter int UNLOCK_BAD = 16,
  parameter int WIN_LEN    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_valid,
  input  logic [65:0] blk,
  output logic        sh_locked,
  output logic        mb_aligned,
  output logic        emb_locked,
  output logic        hdr_err,
  output logic        eomb_err,
  output logic        eoemb_err,
  output logic        cmd_par_err,
  output logic        crc_err,
  output logic        sh_unlock_err,
  output logic        emb_unlock_err,
  output logic        cmd_valid,
  output logic [10:0] cmd_bits
);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int BW = $clog2(UNLOCK_BAD + 1);
  localparam int EW = $clog2(EMB_LEN + 1);

  function automatic logic [11:0] crc12(input logic [11:0] cin, input logic [63:0] d);
    logic [11:0] r;
    logic fb;
    r = cin;
    for (int i = 63; i >= 0; i--) begin
      fb = r[11] ^ d[i];
      r  = {r[10:0], 1'b0} ^ (fb ? 12'h80F : 12'h000);
    end
    return r;
  endfunction

  logic [GW-1:0] good_cnt;
  logic [WW-1:0] win_cnt;
  logic [BW-1:0] bad_cnt;
  logic [EW-1:0] emb_cnt;
  logic [4:0]    pos;
  logic [31:0]   sw;
  logic [11:0]   crc_run, crc_prev;
  logic          crc_ok, emb_cand;

  logic          hv;
  logic [31:0]   sw_n;
  logic          pilot_ok, marker, emb_last, sh_drop;
  logic [BW-1:0] bad_n;
  logic [11:0]   crc_nx, rx_crc;
  logic [10:0]   rx_cmd;

  assign hv       = blk[65] ^ blk[64];
  assign sw_n     = {blk[65], sw[31:1]};
  assign pilot_ok = sw_n[31] & ~(sw_n[15] | sw_n[19] | sw_n[23] | sw_n[27]);
  assign marker   = sw_n[11];
  assign emb_last = (emb_cnt == EW'(EMB_LEN - 1));
  assign bad_n    = bad_cnt + {{(BW-1){1'b0}}, ~hv};
  assign sh_drop  = ~hv & (bad_n == BW'(UNLOCK_BAD));
  assign crc_nx   = crc12(crc_run, blk[63:0]);

  always_comb begin
    for (int i = 0; i < 12; i++) rx_crc[11-i] = sw_n[i + i/3];
    for (int j = 0; j < 11; j++) rx_cmd[10-j] = sw_n[(12+j) + (12+j)/3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_locked <= 1'b0; mb_aligned <= 1'b0; emb_locked <= 1'b0;
      hdr_err <= 1'b0; eomb_err <= 1'b0; eoemb_err <= 1'b0; cmd_par_err <= 1'b0;
      crc_err <= 1'b0; sh_unlock_err <= 1'b0; emb_unlock_err <= 1'b0;
      cmd_valid <= 1'b0; cmd_bits <= '0;
      good_cnt <= '0; win_cnt <= '0; bad_cnt <= '0; emb_cnt <= '0; pos <= '0;
      sw <= '0; crc_run <= '0; crc_prev <= '0; crc_ok <= 1'b0; emb_cand <= 1'b0;
    end else begin
      hdr_err <= 1'b0; eomb_err <= 1'b0; eoemb_err <= 1'b0; cmd_par_err <= 1'b0;
      crc_err <= 1'b0; sh_unlock_err <= 1'b0; emb_unlock_err <= 1'b0; cmd_valid <= 1'b0;
      if (blk_valid) begin
        sw <= sw_n;
        if (!sh_locked) begin
          if (!hv) good_cnt <= '0;
          else if (good_cnt == GW'(LOCK_GOOD - 1)) begin
            sh_locked <= 1'b1; good_cnt <= '0; win_cnt <= '0; bad_cnt <= '0;
          end else good_cnt <= good_cnt + GW'(1);
        end else if (sh_drop) begin
          sh_locked <= 1'b0; sh_unlock_err <= 1'b1; hdr_err <= 1'b1;
          mb_aligned <= 1'b0; emb_locked <= 1'b0; emb_cand <= 1'b0; crc_ok <= 1'b0;
        end else begin
          hdr_err <= ~hv;
          if (win_cnt == WW'(WIN_LEN - 1)) begin
            win_cnt <= '0; bad_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + WW'(1); bad_cnt <= bad_n;
          end
          if (!mb_aligned) begin
            if (pilot_ok) begin
              mb_aligned <= 1'b1; pos <= '0; crc_run <= '0; crc_ok <= 1'b0;
            end
          end else if (pos != 5'd31) begin
            pos <= pos + 5'd1; crc_run <= crc_nx;
          end else begin
            pos <= '0; crc_run <= '0; crc_prev <= crc_nx;
            if (!pilot_ok) begin
              eomb_err <= 1'b1; mb_aligned <= 1'b0; crc_ok <= 1'b0;
              emb_unlock_err <= emb_locked; emb_locked <= 1'b0; emb_cand <= 1'b0;
            end else begin
              crc_ok <= 1'b1; cmd_valid <= 1'b1; cmd_bits <= rx_cmd;
              cmd_par_err <= ^{rx_cmd, sw_n[30]};
              crc_err <= crc_ok & (rx_crc != crc_prev);
              if (emb_locked) begin
                if (marker != emb_last) begin
                  eoemb_err <= 1'b1; emb_unlock_err <= 1'b1;
                  emb_locked <= 1'b0; emb_cand <= 1'b0; emb_cnt <= '0;
                end else emb_cnt <= emb_last ? '0 : emb_cnt + EW'(1);
              end else if (marker) begin
                if (emb_cand && emb_last) emb_locked <= 1'b1;
                emb_cand <= 1'b1; emb_cnt <= '0;
              end else if (emb_cand) begin
                if (emb_last) emb_cand <= 1'b0;
                else emb_cnt <= emb_cnt + EW'(1);
              end
            end
          end
        end
      end
    end
  end
endmodule

module syncword_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        blk_valid,
  input logic        sh_locked,
  input logic        mb_aligned,
  input logic        emb_locked,
  input logic        hdr_err,
  input logic        eomb_err,
  input logic        eoemb_err,
  input logic        cmd_par_err,
  input logic        crc_err,
  input logic        sh_unlock_err,
  input logic        emb_unlock_err,
  input logic        cmd_valid,
  input logic [10:0] cmd_bits
);
  a_r2_hdr_err_locked: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> (sh_locked || sh_unlock_err));
  a_r3_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sh_unlock_err |-> (!sh_locked && !mb_aligned && !emb_locked));
  a_r4_align_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_aligned) |-> sh_locked);
  a_r5_eomb_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    eomb_err |-> (!cmd_valid && !mb_aligned && !crc_err && !cmd_par_err));
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_bits));
  a_r7_crc_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> cmd_valid);
  a_r8_emb_needs_mb: assert property (@(posedge clk) disable iff (!rst_n)
    emb_locked |-> mb_aligned);
  a_r9_eoemb_drop: assert property (@(posedge clk) disable iff (!rst_n)
    eoemb_err |-> (emb_unlock_err && !emb_locked));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> (!hdr_err && !cmd_valid && !eomb_err && !sh_unlock_err));
endmodule

bind syncword_checker syncword_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .sh_locked(sh_locked),
  .mb_aligned(mb_aligned), .emb_locked(emb_locked), .hdr_err(hdr_err),
  .eomb_err(eomb_err), .eoemb_err(eoemb_err), .cmd_par_err(cmd_par_err),
  .crc_err(crc_err), .sh_unlock_err(sh_unlock_err), .emb_unlock_err(emb_unlock_err),
  .cmd_valid(cmd_valid), .cmd_bits(cmd_bits)
);

// File: tb/syncword_checker_bench.sv
module syncword_checker_bench;
  localparam int E = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0;
  logic [65:0] blk = '0;
  logic        sh_locked, mb_aligned, emb_locked, hdr_err, eomb_err, eoemb_err;
  logic        cmd_par_err, crc_err, sh_unlock_err, emb_unlock_err, cmd_valid;
  logic [10:0] cmd_bits;

  syncword_checker #(.EMB_LEN(E)) u_syncword_checker (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk(blk),
    .sh_locked(sh_locked), .mb_aligned(mb_aligned), .emb_locked(emb_locked),
    .hdr_err(hdr_err), .eomb_err(eomb_err), .eoemb_err(eoemb_err),
    .cmd_par_err(cmd_par_err), .crc_err(crc_err), .sh_unlock_err(sh_unlock_err),
    .emb_unlock_err(emb_unlock_err), .cmd_valid(cmd_valid), .cmd_bits(cmd_bits)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int c_hdr, c_eomb, c_eoemb, c_par, c_crc, c_shu, c_embu, c_cmd;
  int nblk = 0, mb_idx = 0;
  logic [11:0] prev_crc = '0;

  always @(negedge clk) if (rst_n) begin
    c_hdr += int'(hdr_err); c_eomb += int'(eomb_err); c_eoemb += int'(eoemb_err);
    c_par += int'(cmd_par_err); c_crc += int'(crc_err); c_shu += int'(sh_unlock_err);
    c_embu += int'(emb_unlock_err); c_cmd += int'(cmd_valid);
  end

  task automatic clr();
    c_hdr = 0; c_eomb = 0; c_eoemb = 0; c_par = 0; c_crc = 0; c_shu = 0; c_embu = 0; c_cmd = 0;
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic logic [11:0] crc_model(input logic [11:0] c, input logic [63:0] d);
    logic [11:0] r = c;
    for (int i = 63; i >= 0; i--) begin
      if (r[11] ^ d[i]) r = {r[10:0], 1'b0} ^ 12'h80F;
      else              r = {r[10:0], 1'b0};
    end
    return r;
  endfunction

  task automatic send_blk(input logic [1:0] h, input logic [63:0] p);
    @(negedge clk);
    blk_valid = 1'b1; blk = {h, p}; nblk++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      blk_valid = 1'b0; blk = {2'b00, 64'hFFFF_FFFF_FFFF_FFFF};
    end
  endtask

  task automatic flush();
    @(negedge clk);
    blk_valid = 1'b0;
    @(posedge clk);
    #2;
  endtask

  task automatic send_mb(input bit zero, input logic [10:0] cmd, input bit f_par, input bit f_crc,
                         input bit f_pilot, input bit f_mark, input int badpos, input int idle_at);
    logic [31:0] w;
    logic [11:0] cf, c;
    logic [63:0] p;
    logic [1:0]  h;
    w = '0; c = '0;
    cf = prev_crc ^ {11'h0, f_crc};
    if (!zero) begin
      for (int i = 0; i < 12; i++) w[i + i/3] = cf[11-i];
      for (int j = 0; j < 11; j++) w[(12+j) + (12+j)/3] = cmd[10-j];
      w[30] = (^cmd) ^ f_par;
      w[11] = ((mb_idx % E) == E - 1) ^ f_mark;
    end
    w[31] = ~f_pilot;
    for (int k = 0; k < 32; k++) begin
      if (k == idle_at) idle(2);
      p = {$urandom, $urandom};
      c = crc_model(c, p);
      h = w[k] ? 2'b10 : 2'b01;
      if (k == badpos) h = 2'b00;
      send_blk(h, p);
    end
    prev_crc = c;
    mb_idx++;
  endtask

  task automatic t_reset();
    check("R10 reset sh_locked", int'(sh_locked), 0);
    check("R10 reset mb_aligned", int'(mb_aligned), 0);
    check("R10 reset emb_locked", int'(emb_locked), 0);
    check("R10 reset cmd_bits", int'(cmd_bits), 0);
  endtask

  task automatic t_header_lock();
    clr();
    for (int i = 0; i < 10; i++) send_blk(2'b01, 64'h0);
    send_blk(2'b11, 64'h0);
    for (int i = 0; i < 63; i++) send_blk(2'b01, 64'h0);
    flush();
    check("R1 no lock after 63 good", int'(sh_locked), 0);
    check("R2 no hdr_err before lock", c_hdr, 0);
    send_blk(2'b01, 64'h0);
    flush();
    check("R1 lock after 64th good", int'(sh_locked), 1);
    nblk = 0;
  endtask

  task automatic t_align();
    clr();
    send_mb(1'b1, 11'h0, 0, 0, 0, 0, -1, -1);
    flush();
    check("R4 mb_aligned after pilot", int'(mb_aligned), 1);
    check("R4 no words before alignment", c_cmd, 0);
  endtask

  task automatic t_clean_and_emb_lock();
    logic [10:0] cmd;
    clr();
    cmd = '0;
    for (int m = 1; m <= 6; m++) begin
      cmd = 11'(m * 11'h155 + 3);
      send_mb(1'b0, cmd, 0, 0, 0, 0, -1, -1);
    end
    flush();
    check("R8 no emb lock after one marker", int'(emb_locked), 0);
    cmd = 11'h6A5;
    send_mb(1'b0, cmd, 0, 0, 0, 0, -1, -1);
    flush();
    check("R8 emb lock after second marker", int'(emb_locked), 1);
    check("R6 cmd_valid per word", c_cmd, 7);
    check("R6 cmd_bits value", int'(cmd_bits), int'(cmd));
    check("R6 no parity error", c_par, 0);
    check("R7 no crc error on clean stream", c_crc, 0);
  endtask

  task automatic t_parity();
    clr();
    send_mb(1'b0, 11'h2F1, 1, 0, 0, 0, -1, -1);
    flush();
    check("R6 parity error pulse", c_par, 1);
    check("R6 parity word still reported", c_cmd, 1);
    check("R7 no crc error with bad parity", c_crc, 0);
  endtask

  task automatic t_crc();
    clr();
    send_mb(1'b0, 11'h013, 0, 1, 0, 0, -1, -1);
    flush();
    check("R7 crc error pulse", c_crc, 1);
    check("R6 no parity error with bad crc", c_par, 0);
  endtask

  task automatic t_hdr_and_idle();
    clr();
    send_mb(1'b0, 11'h3C3, 0, 0, 0, 0, 3, 9);
    flush();
    check("R2 one hdr_err for one bad header", c_hdr, 1);
    check("R10 idle garbage ignored, word intact", c_cmd, 1);
    check("R10 idle cycles leave crc intact", c_crc, 0);
    check("R2 lock kept after one bad header", int'(sh_locked), 1);
  endtask

  task automatic t_marker();
    clr();
    send_mb(1'b0, 11'h111, 0, 0, 0, 1, -1, -1);
    flush();
    check("R9 eoemb_err pulse", c_eoemb, 1);
    check("R9 emb_unlock_err pulse", c_embu, 1);
    check("R9 emb lock dropped", int'(emb_locked), 0);
    check("R9 multiblock alignment kept", int'(mb_aligned), 1);
    for (int m = 0; m < 7; m++) send_mb(1'b0, 11'h0A0, 0, 0, 0, 0, -1, -1);
    flush();
    check("R9 no relock after one marker", int'(emb_locked), 0);
    send_mb(1'b0, 11'h0A0, 0, 0, 0, 0, -1, -1);
    flush();
    check("R9 relock after marker search", int'(emb_locked), 1);
    check("R9 no further eoemb_err", c_eoemb, 1);
  endtask

  task automatic t_pilot();
    clr();
    send_mb(1'b0, 11'h7FF, 1, 1, 1, 0, -1, -1);
    flush();
    check("R5 eomb_err pulse", c_eomb, 1);
    check("R5 word suppressed", c_cmd, 0);
    check("R5 no crc/parity report", c_crc + c_par, 0);
    check("R5 emb_unlock_err pulse", c_embu, 1);
    check("R5 alignment dropped", int'(mb_aligned), 0);
    check("R5 emb lock dropped", int'(emb_locked), 0);
    send_mb(1'b1, 11'h0, 0, 0, 0, 0, -1, -1);
    flush();
    check("R4 realigned after clean pilot", int'(mb_aligned), 1);
    clr();
    send_mb(1'b0, 11'h246, 0, 0, 0, 0, -1, -1);
    send_mb(1'b0, 11'h135, 0, 0, 0, 0, -1, -1);
    flush();
    check("R7 no crc error after realignment", c_crc, 0);
    check("R7 words after realignment", c_cmd, 2);
  endtask

  task automatic t_unlock();
    while (nblk % 64 != 0) send_blk(2'b01, 64'h0);
    clr();
    for (int i = 0; i < 15; i++) send_blk(2'b11, 64'h0);
    while (nblk % 64 != 0) send_blk(2'b01, 64'h0);
    flush();
    check("R3 lock kept with 15 bad in window", int'(sh_locked), 1);
    check("R2 hdr_err count", c_hdr, 15);
    check("R3 no unlock yet", c_shu, 0);
    clr();
    for (int i = 0; i < 16; i++) send_blk(2'b00, 64'h0);
    flush();
    check("R3 sh_unlock_err pulse", c_shu, 1);
    check("R3 lock lost", int'(sh_locked), 0);
    check("R3 alignment cleared", int'(mb_aligned), 0);
    for (int i = 0; i < 63; i++) send_blk(2'b10, 64'h0);
    flush();
    check("R3 not relocked after 63", int'(sh_locked), 0);
    send_blk(2'b10, 64'h0);
    flush();
    check("R3 relocked automatically", int'(sh_locked), 1);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_header_lock();
    t_align();
    t_clean_and_emb_lock();
    t_parity();
    t_crc();
    t_hdr_and_idle();
    t_marker();
    t_pilot();
    t_unlock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule